// File: doc/BRIEF.md
# I2C Target with Strap Addressing and High-Speed Entry

This block is the two-wire serial target front end of a data-converter style device. It watches pre-synchronized samples of the clock and data lines, works out its own 7-bit bus address from two pin-strapped inputs that can each be tied low, tied high or left open, and answers only to that address. Through it a bus controller reads a 16-bit two's complement conversion result and reads or writes an 8-bit configuration register.

The block also detects the high-speed controller code, a first byte of the form `00001xxx`. It never acknowledges that byte. It raises a mode flag, which the surrounding logic uses to switch its line filters, and holds the flag across repeated STARTs until the next STOP. The result register is loaded by a valid strobe from the conversion logic. It is copied into a snapshot when a read is addressed, so the two bytes of one read always belong to the same conversion.

Top module: `i2c_hs_target`

## Requirements
- R1: Each strap input is coded 2'b00 = low, 2'b01 = high, 2'b1x = open. The device address is 1001 followed by three bits, given here as (strap A, strap B) → bits: (low,low) 000, (low,open) 001, (low,high) 010, (open,low) 011, (high,low) 100, (high,open) 101, (high,high) 110, (open,high) 111. The block acknowledges an address byte with that address by asserting `sda_oe_o` for the whole ACK clock. Bit 0 of the address byte is 1 for a read.
- R2: When both straps are open, the block acknowledges no address byte at all.
- R3: A first byte after START or repeated START whose top five bits are 00001 is the high-speed code. Its bit 0 is not a read flag. `sda_oe_o` stays low during that byte and its ACK clock.
- R4: `hs_mode_o` rises one clock after the SCL rising edge that samples bit 0 of the high-speed code. It stays high through a repeated START and a following transfer, and it falls one clock after a STOP. It is low after reset.
- R5: A read returns the result's upper byte, then its lower byte, then the configuration byte, which repeats for any further bytes. Each byte goes out most significant bit first. `sda_oe_o` changes only in the clock after an SCL falling edge.
- R6: After the controller answers a read byte with NACK, `sda_oe_o` stays low through any further SCL pulses until the next START. It is also low after reset.
- R7: Every data byte written after an acknowledged write address replaces `cfg_o` and is acknowledged. `cfg_o` resets to 8'h0C.
- R8: After reset the result register reads zero until the first valid strobe loads it.
- R9: The result is captured when the read address byte completes. A valid strobe that arrives during the read does not change the bytes of that read, and it shows up on the next read.
- R10: A START in the middle of a transfer ends it and begins a new address phase. A STOP in the middle of a byte ends the transfer with the partial byte discarded.
- R11: After an address byte that does not match, the block acknowledges nothing, stores nothing and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (wired bus level) |
| strap_a_i | input | 2 | First address strap state (00 low, 01 high, 1x open) |
| strap_b_i | input | 2 | Second address strap state (00 low, 01 high, 1x open) |
| res_vld_i | input | 1 | Strobe loading a new conversion result |
| res_data_i | input | 16 | Conversion result, two's complement |
| sda_oe_o | output | 1 | Pull SDA low when high (open-drain enable) |
| hs_mode_o | output | 1 | High-speed mode flag |
| cfg_o | output | 8 | Configuration register value |

## Verification
The hardest situations to reach from the ports are a controller abort while the block sits in the middle of sending a byte, and a result strobe that lands between the two bytes of one read. The stimulus reaches the abort by loading a result whose top bit is 1, so the line is released on the first data bit, and then issuing a repeated START at once. It reaches the coherence case by pulsing the strobe during the ACK gap after the upper byte. It then reads again to show that the new value appears only in the next read.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    // Strap pin coding: bit 1 set means the pin is left open.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_OPEN = 2'b10
    } strap_lvl_e;

    typedef struct packed {
        logic       ok;
        logic [6:0] addr;
    } dev_addr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_AHOLD,
        ST_WDATA,
        ST_WACK,
        ST_WHOLD,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } tgt_state_e;

    localparam logic [4:0] HS_CODE_PFX = 5'b00001;
    localparam logic [3:0] ADDR_BASE   = 4'b1001;

    // Three-level strap pair to 7-bit address. Both open is invalid.
    function automatic dev_addr_t strap_to_addr(input logic [1:0] pa, input logic [1:0] pb);
        dev_addr_t r;
        logic      a_open;
        logic      b_open;
        a_open    = pa[1];
        b_open    = pb[1];
        r.ok      = !(a_open && b_open);
        r.addr[6:3] = ADDR_BASE;
        if (a_open) begin
            r.addr[2:0] = {pb[0], 2'b11};
        end else begin
            r.addr[2:0] = {pa[0], (b_open ? 2'b01 : {pb[0], 1'b0})};
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Data moving while the clock stays high marks a bus condition.
    always_comb begin
        ev_start = scl_i && scl_q && sda_q && !sda_i;
        ev_stop  = scl_i && scl_q && !sda_q && sda_i;
        ev_rise  = scl_i && !scl_q;
        ev_fall  = !scl_i && scl_q;
    end

endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode
    import i2c_hs_pkg::*;
(
    input  logic [1:0] strap_a_i,
    input  logic [1:0] strap_b_i,
    output dev_addr_t  addr_o
);
    always_comb begin
        addr_o = strap_to_addr(strap_a_i, strap_b_i);
    end
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
    import i2c_hs_pkg::*;
#(
    parameter int         RES_W     = 16,
    parameter logic [7:0] CFG_RESET = 8'h0C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       strap_a_i,
    input  logic [1:0]       strap_b_i,
    input  logic             res_vld_i,
    input  logic [RES_W-1:0] res_data_i,
    output logic             sda_oe_o,
    output logic             hs_mode_o,
    output logic [7:0]       cfg_o
);
    localparam int               RES_BYTES = RES_W / 8;
    localparam int               IDX_W     = $clog2(RES_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_CFG   = IDX_W'(RES_BYTES);
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

    logic       ev_start, ev_stop, ev_rise, ev_fall;
    dev_addr_t  self_addr;

    tgt_state_e       state_q;
    logic [2:0]       bitcnt_q;
    logic [6:0]       rx_q;
    logic [7:0]       tx_q;
    logic [IDX_W-1:0] idx_q;
    logic             rnw_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] snap_q;
    logic [7:0]       cfg_q;
    logic             oe_q;
    logic             hs_q;
    logic [7:0]       rx_byte;
    logic [7:0]       sel_byte;

    i2c_line_events u_events (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    i2c_strap_decode u_strap (
        .strap_a_i (strap_a_i),
        .strap_b_i (strap_b_i),
        .addr_o    (self_addr)
    );

    assign rx_byte = {rx_q, sda_i};

    // Read byte selection: snapshot bytes high to low, then configuration.
    always_comb begin
        sel_byte = cfg_q;
        for (int k = 0; k < RES_BYTES; k++) begin
            if (idx_q == IDX_W'(k)) begin
                sel_byte = snap_q[RES_W-1-8*k -: 8];
            end
        end
    end

    // Result holding register, zero until the first strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (res_vld_i) begin
            res_q <= res_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            idx_q    <= '0;
            rnw_q    <= 1'b0;
            snap_q   <= '0;
            cfg_q    <= CFG_RESET;
            oe_q     <= 1'b0;
            hs_q     <= 1'b0;
        end else if (ev_stop) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            hs_q    <= 1'b0;
        end else if (ev_start) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR: if (ev_rise) begin
                    rx_q     <= rx_byte[6:0];
                    bitcnt_q <= bitcnt_q + 3'd1;
                    if (bitcnt_q == 3'd7) begin
                        if (rx_byte[7:3] == HS_CODE_PFX) begin
                            hs_q    <= 1'b1;
                            state_q <= ST_SKIP;
                        end else if (self_addr.ok && rx_byte[7:1] == self_addr.addr) begin
                            rnw_q   <= rx_byte[0];
                            state_q <= ST_AACK;
                            if (rx_byte[0]) begin
                                snap_q <= res_q;
                                idx_q  <= '0;
                            end
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                end
                ST_AACK: if (ev_fall) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_AHOLD;
                end
                ST_AHOLD: if (ev_fall) begin
                    bitcnt_q <= '0;
                    if (rnw_q) begin
                        tx_q    <= sel_byte;
                        oe_q    <= ~sel_byte[7];
                        state_q <= ST_RDATA;
                    end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_WDATA;
                    end
                end
                ST_WDATA: if (ev_rise) begin
                    rx_q     <= rx_byte[6:0];
                    bitcnt_q <= bitcnt_q + 3'd1;
                    if (bitcnt_q == 3'd7) begin
                        cfg_q   <= rx_byte;
                        state_q <= ST_WACK;
                    end
                end
                ST_WACK: if (ev_fall) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_WHOLD;
                end
                ST_WHOLD: if (ev_fall) begin
                    oe_q     <= 1'b0;
                    bitcnt_q <= '0;
                    state_q  <= ST_WDATA;
                end
                ST_RDATA: if (ev_fall) begin
                    if (bitcnt_q == 3'd7) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RACK;
                    end else begin
                        bitcnt_q <= bitcnt_q + 3'd1;
                        tx_q     <= {tx_q[6:0], 1'b0};
                        oe_q     <= ~tx_q[6];
                    end
                end
                ST_RACK: if (ev_rise) begin
                    if (sda_i) begin
                        state_q <= ST_SKIP;
                    end else begin
                        if (idx_q != IDX_CFG) begin
                            idx_q <= idx_q + IDX_ONE;
                        end
                        state_q <= ST_RNEXT;
                    end
                end
                ST_RNEXT: if (ev_fall) begin
                    tx_q     <= sel_byte;
                    oe_q     <= ~sel_byte[7];
                    bitcnt_q <= '0;
                    state_q  <= ST_RDATA;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o  = oe_q;
    assign hs_mode_o = hs_q;
    assign cfg_o     = cfg_q;

    // R4: the mode flag is gone one clock after a STOP.
    p_hs_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !hs_mode_o);

    // R3: the mode flag can only come from a completed address-phase byte.
    p_hs_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode_o) |-> $past(state_q == ST_ADDR));

    // R5: the data enable moves only behind a clock-low sample or a bus condition.
    p_oe_edge_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> $past(!scl_i || ev_start || ev_stop));

    // R6: no drive while idle or while ignoring the bus.
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_SKIP) |-> !sda_oe_o);

    // R7: configuration changes only out of a write data byte.
    p_cfg_src_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> $past(state_q == ST_WDATA));

    // R9: snapshot frozen while bytes are shifting out.
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RDATA && $past(state_q == ST_RDATA)) |-> $stable(snap_q));

endmodule

// File: tb/i2c_hs_target_tb.sv
module i2c_hs_target_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        scl;
    logic        msda;
    logic        sda_line;
    logic [1:0]  strap_a, strap_b;
    logic        res_vld;
    logic [15:0] res_data;
    logic        sda_oe, hs_mode;
    logic [7:0]  cfg;

    logic        exp_oe, exp_hs;
    logic [7:0]  exp_cfg;
    logic        mon_en = 1'b0;
    string       cur_req = "R6";
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = msda & ~sda_oe;

    i2c_hs_target u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_a_i  (strap_a),
        .strap_b_i  (strap_b),
        .res_vld_i  (res_vld),
        .res_data_i (res_data),
        .sda_oe_o   (sda_oe),
        .hs_mode_o  (hs_mode),
        .cfg_o      (cfg)
    );

    task automatic check(input logic ok, input string what, input int act, input int expv);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", what, act, expv, $time);
        end
    endtask

    // Reference model comparison every clock, 2 ns after the rising edge.
    always @(posedge clk) begin
        #2;
        if (mon_en) begin
            check(sda_oe === exp_oe, {cur_req, " sda_oe"}, int'(sda_oe), int'(exp_oe));
            check(hs_mode === exp_hs, {cur_req, " hs_mode"}, int'(hs_mode), int'(exp_hs));
            check(cfg === exp_cfg, {cur_req, " cfg"}, int'(cfg), int'(exp_cfg));
        end
    end

    // Address expected from strap levels (0 low, 1 high, 2 open); -1 = none.
    function automatic int ref_addr(input int a, input int b);
        if (a == 2 && b == 2) return -1;
        if (a == 2) return (b == 0) ? 'h4B : 'h4F;
        return 'h48 + a * 4 + ((b == 0) ? 0 : (b == 2) ? 1 : 2);
    endfunction

    function automatic logic [1:0] pin_code(input int l);
        return (l == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b10;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b0; step(4); scl = 1'b0; step(2);
    endtask

    task automatic bus_rstart();
        msda = 1'b1; step(2); scl = 1'b1; step(4); msda = 1'b0; step(4); scl = 1'b0; step(2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; step(2); scl = 1'b1; step(4);
        msda = 1'b1; exp_hs = 1'b0; exp_oe = 1'b0; step(4);
    endtask

    task automatic clock_pulses(input int n);
        msda = 1'b1;
        for (int i = 0; i < n; i++) begin
            step(2); scl = 1'b1; step(4); scl = 1'b0; step(2);
        end
    endtask

    task automatic pulse_result(input logic [15:0] v);
        res_data = v; res_vld = 1'b1; step(1); res_vld = 1'b0; step(1);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic want_ack, input logic oe_after,
                           input logic is_addr, input logic cfg_store, input string tag);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; step(2); scl = 1'b1;
            if (i == 0) begin
                if (is_addr && b[7:3] == 5'b00001) exp_hs = 1'b1;
                if (cfg_store) exp_cfg = b;
            end
            step(4); scl = 1'b0;
            if (i == 0) exp_oe = want_ack;
            step(2);
        end
        msda = 1'b1; step(2); scl = 1'b1; step(2);
        check(sda_line === ~want_ack, {tag, " ack slot"}, int'(sda_line), int'(~want_ack));
        step(2); scl = 1'b0; exp_oe = oe_after; step(2);
    endtask

    task automatic rd_byte(input logic [7:0] e, input logic mack, input logic oe_after, input string tag);
        logic [7:0] got;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; step(2); scl = 1'b1; step(2);
            got[i] = sda_line;
            step(2); scl = 1'b0;
            exp_oe = (i > 0) ? ~e[(i > 0) ? i - 1 : 0] : 1'b0;
            step(2);
        end
        check(got === e, {tag, " read byte"}, int'(got), int'(e));
        msda = ~mack; step(2); scl = 1'b1; step(4); scl = 1'b0; exp_oe = oe_after; step(2);
        msda = 1'b1;
    endtask

    task automatic probe(input logic [6:0] a, input logic want, input string tag);
        bus_start();
        wr_byte({a, 1'b0}, want, 1'b0, 1'b1, 1'b0, tag);
        bus_stop();
    endtask

    initial begin
        rst = 1'b1; scl = 1'b1; msda = 1'b1;
        strap_a = 2'b00; strap_b = 2'b00;
        res_vld = 1'b0; res_data = '0;
        exp_oe = 1'b0; exp_hs = 1'b0; exp_cfg = 8'h0C;
        step(5);
        rst = 1'b0;
        step(1);
        check(sda_oe === 1'b0, "R6 reset sda_oe", int'(sda_oe), 0);
        check(hs_mode === 1'b0, "R4 reset hs_mode", int'(hs_mode), 0);
        check(cfg === 8'h0C, "R7 reset cfg", int'(cfg), 'h0C);
        mon_en = 1'b1;

        // R8: result reads zero before any strobe.
        cur_req = "R8";
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        rd_byte(8'h00, 1'b1, 1'b1, "R8");
        rd_byte(8'h00, 1'b1, 1'b1, "R8");
        rd_byte(8'h0C, 1'b0, 1'b0, "R8");
        bus_stop();
        pulse_result(16'hA53C);

        // R7: write configuration, then R5 read order with config repeat, R6 after NACK.
        cur_req = "R7";
        bus_start();
        wr_byte({7'h48, 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        wr_byte(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        bus_stop();
        cur_req = "R5";
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        rd_byte(8'hA5, 1'b1, 1'b1, "R5");
        rd_byte(8'h3C, 1'b1, 1'b1, "R5");
        rd_byte(8'h5A, 1'b1, 1'b1, "R5");
        rd_byte(8'h5A, 1'b0, 1'b0, "R5");
        cur_req = "R6";
        clock_pulses(9);
        check(sda_oe === 1'b0, "R6 released after NACK", int'(sda_oe), 0);
        bus_stop();

        // R1 / R2: every strap combination.
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                int ra;
                strap_a = pin_code(a); strap_b = pin_code(b);
                ra = ref_addr(a, b);
                step(2);
                if (ra >= 0) begin
                    cur_req = "R1";
                    probe(7'(ra), 1'b1, "R1");
                    probe(7'(ra) ^ 7'h04, 1'b0, "R1");
                end else begin
                    cur_req = "R2";
                    for (int k = 'h48; k <= 'h4F; k++) probe(7'(k), 1'b0, "R2");
                end
            end
        end
        cur_req = "R2";
        strap_a = 2'b11; strap_b = 2'b10; step(2);
        probe(7'h4B, 1'b0, "R2");
        probe(7'h4F, 1'b0, "R2");
        strap_a = 2'b00; strap_b = 2'b00; step(2);

        // R11: mismatching address followed by data is ignored.
        cur_req = "R11";
        bus_start();
        wr_byte({7'h49, 1'b0}, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
        wr_byte(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        bus_stop();
        check(cfg === 8'h5A, "R11 cfg untouched", int'(cfg), 'h5A);

        // R3 / R4: high-speed code, repeated START, transfer, STOP.
        cur_req = "R3";
        bus_start();
        wr_byte(8'h0B, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
        check(hs_mode === 1'b1, "R4 hs set after code", int'(hs_mode), 1);
        cur_req = "R4";
        bus_rstart();
        wr_byte({7'h48, 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        wr_byte(8'h33, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        check(hs_mode === 1'b1, "R4 hs held across rstart", int'(hs_mode), 1);
        bus_stop();
        check(hs_mode === 1'b0, "R4 hs cleared by stop", int'(hs_mode), 0);

        // R9: strobe between bytes of one read.
        cur_req = "R9";
        pulse_result(16'h1234);
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        rd_byte(8'h12, 1'b1, 1'b1, "R9");
        pulse_result(16'hFFFF);
        rd_byte(8'h34, 1'b1, 1'b1, "R9");
        rd_byte(8'h33, 1'b0, 1'b0, "R9");
        bus_stop();
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        rd_byte(8'hFF, 1'b1, 1'b0, "R9");
        rd_byte(8'hFF, 1'b0, 1'b0, "R9");
        bus_stop();

        // R10: repeated START during a read, STOP inside a write byte.
        cur_req = "R10";
        pulse_result(16'h8001);
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        bus_rstart();
        wr_byte({7'h48, 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        wr_byte(8'h77, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        bus_stop();
        bus_start();
        wr_byte({7'h48, 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 3; i++) begin
            msda = 1'b0; step(2); scl = 1'b1; step(4); scl = 1'b0; step(2);
        end
        bus_stop();
        check(cfg === 8'h77, "R10 partial byte dropped", int'(cfg), 'h77);
        bus_start();
        wr_byte({7'h48, 1'b0}, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        wr_byte(8'h21, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
        bus_stop();
        bus_start();
        wr_byte({7'h48, 1'b1}, 1'b1, 1'b0, 1'b1, 1'b0, "R10");
        rd_byte(8'h80, 1'b1, 1'b1, "R10");
        rd_byte(8'h01, 1'b0, 1'b0, "R10");
        bus_stop();

        step(4);
        mon_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog during %s act=running exp=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule